// File: doc/BRIEF.md
# Configurable Debug Event Counter

This block is a debug performance counter built on one 40-bit storage register. In benchmark mode the whole register counts qualified CPU cycles. In event mode the low 32 bits work either as one 32-bit counter or as two independent 16-bit counters. Each event counter has its own match value and raises a debug-event pulse when a counted action finds the counter equal to that value.

The match test uses the count before it advances. A counter loaded with 0 and a match value of 0 therefore fires on its first counted action and reads 1 afterwards. A clear strobe, normally driven by a breakpoint or watchpoint hit, returns a counter to zero. This gives a watchdog: if the expected address is not seen before the count reaches the match value, a debug event is raised.

Three registers are written through the write ports: the initial value, the match value and the mode. Writing the mode also loads the counter from the initial value.

Top module: `dbg_evt_counter`

## Requirements
- R1: After reset the mode is benchmark (code 0), the initial value and the match value are 0, `cnt_val` is 0 and `dbg_evt` is 0.
- R2: In benchmark mode (code 0) all 40 bits form one counter. It advances by one on each cycle with `cnt_en[0]` high and wraps from all ones to 0. `dbg_evt` stays 0 in this mode.
- R3: In 32-bit event mode (code 1), bits 31:0 count on `cnt_en[0]` and wrap from 0xFFFFFFFF to 0. Bits 39:32 keep their value. `dbg_evt[1]`, `cnt_en[1]` and `clr_hit[1]` have no effect and `dbg_evt[1]` stays 0.
- R4: In an event mode, a counted action that finds the counter equal to its match value raises that lane's `dbg_evt` bit for that same cycle only. The counter still advances on that action, so init 0 with match 0 fires on the first action and then reads 1.
- R5: In 16-bit event mode (code 2), lane 0 is bits 15:0 and lane 1 is bits 31:16. Each lane has its own `cnt_en[i]`, `clr_hit[i]` and `dbg_evt[i]`. Lane 0 compares against match bits 15:0 and lane 1 against match bits 31:16. A lane wraps with no carry into the other lane, and bits 39:32 keep their value.
- R6: `clr_hit[i]` zeroes its counter on the next edge in any mode except frozen: the whole 40 bits in benchmark mode, bits 31:0 in 32-bit mode, and lane i in 16-bit mode. A clear overrides a count in the same cycle, and no event is raised in that cycle.
- R7: A cycle with `mode_we` high selects the mode `mode_wdata` and loads all 40 counter bits with the initial value held before that cycle. In that cycle nothing is counted and no event is raised.
- R8: `init_we` and `match_we` store their data on the clock edge and leave the counter unchanged. A new match value is used from the next cycle on.
- R9: In frozen mode (code 3) the counter holds its value, and count and clear strobes raise no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 2 | Count-action strobe, one per lane (bit 0 also drives the wide counters) |
| clr_hit | input | 2 | Breakpoint/watchpoint clear strobe, one per lane |
| mode_we | input | 1 | Mode register write strobe; also reloads the counter |
| mode_wdata | input | 2 | Mode code: 0 benchmark, 1 event 32-bit, 2 event 16-bit, 3 frozen |
| init_we | input | 1 | Initial-value register write strobe |
| init_wdata | input | 40 | Initial value |
| match_wdata | input | 32 | Match value (16-bit mode: low half lane 0, high half lane 1) |
| match_we | input | 1 | Match register write strobe |
| cnt_val | output | 40 | Current counter storage |
| dbg_evt | output | 2 | Debug-event pulse per lane |

## Verification
The bench checks the zero-match case. A design that compared after the increment would miss the first event, and one that gated the increment on a hit would read 0 instead of 1 afterwards. It checks 16-bit lane wrap, where a shared adder would carry into lane 1, and 32-bit wrap, where a full-width adder would disturb bits 39:32. It also checks a clear together with a count, and a mode write together with a count on a matching value. A wrong priority in either case would show as a leftover count or a spurious pulse.

// File: rtl/dbg_cnt_pkg.sv
package dbg_cnt_pkg;

    typedef enum logic [1:0] {
        MODE_BENCH = 2'd0,
        MODE_EVT32 = 2'd1,
        MODE_EVT16 = 2'd2,
        MODE_HOLD  = 2'd3
    } cnt_mode_e;

endpackage

// File: rtl/dbg_cnt_step.sv
// Next value of one counter slice: clear beats count, natural wrap.
module dbg_cnt_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] cur,
    input  logic         en,
    input  logic         clr,
    output logic [W-1:0] nxt
);
    always_comb begin
        if (clr)      nxt = '0;
        else if (en)  nxt = cur + W'(1);
        else          nxt = cur;
    end
endmodule

// File: rtl/dbg_cnt_cmp.sv
// Match test on the pre-increment value of one event counter.
module dbg_cnt_cmp #(
    parameter int W = 16
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] match,
    input  logic         en,
    input  logic         clr,
    output logic         hit
);
    always_comb hit = en && !clr && (cur == match);
endmodule

// File: rtl/dbg_evt_counter.sv
module dbg_evt_counter
    import dbg_cnt_pkg::*;
#(
    parameter int WIDE_W = 40,
    parameter int EVT_W  = 32,
    parameter int LANE_W = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [EVT_W/LANE_W-1:0]     cnt_en,
    input  logic [EVT_W/LANE_W-1:0]     clr_hit,
    input  logic                        mode_we,
    input  logic [1:0]                  mode_wdata,
    input  logic                        init_we,
    input  logic [WIDE_W-1:0]           init_wdata,
    input  logic [EVT_W-1:0]            match_wdata,
    input  logic                        match_we,
    output logic [WIDE_W-1:0]           cnt_val,
    output logic [EVT_W/LANE_W-1:0]     dbg_evt
);
    localparam int N_LANES = EVT_W / LANE_W;

    typedef struct packed {
        cnt_mode_e          mode;
        logic [WIDE_W-1:0]  cnt;
        logic [WIDE_W-1:0]  init;
        logic [EVT_W-1:0]   match;
    } st_t;

    st_t st_d, st_q;

    cnt_mode_e          mode_q;
    logic [WIDE_W-1:0]  init_q;
    assign mode_q = st_q.mode;
    assign init_q = st_q.init;

    // Benchmark counter: full width, no match.
    logic [WIDE_W-1:0] wide_nxt;
    dbg_cnt_step #(.W(WIDE_W)) u_wide_step (
        .cur (st_q.cnt),
        .en  (cnt_en[0]),
        .clr (clr_hit[0]),
        .nxt (wide_nxt)
    );

    // Single event counter.
    logic [EVT_W-1:0] e32_nxt;
    logic             e32_hit;
    dbg_cnt_step #(.W(EVT_W)) u_e32_step (
        .cur (st_q.cnt[EVT_W-1:0]),
        .en  (cnt_en[0]),
        .clr (clr_hit[0]),
        .nxt (e32_nxt)
    );
    dbg_cnt_cmp #(.W(EVT_W)) u_e32_cmp (
        .cur   (st_q.cnt[EVT_W-1:0]),
        .match (st_q.match),
        .en    (cnt_en[0]),
        .clr   (clr_hit[0]),
        .hit   (e32_hit)
    );

    // Split event counters, one per lane, no carry between them.
    logic [EVT_W-1:0]   lane_nxt;
    logic [N_LANES-1:0] lane_hit;
    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        dbg_cnt_step #(.W(LANE_W)) u_step (
            .cur (st_q.cnt[g*LANE_W +: LANE_W]),
            .en  (cnt_en[g]),
            .clr (clr_hit[g]),
            .nxt (lane_nxt[g*LANE_W +: LANE_W])
        );
        dbg_cnt_cmp #(.W(LANE_W)) u_cmp (
            .cur   (st_q.cnt[g*LANE_W +: LANE_W]),
            .match (st_q.match[g*LANE_W +: LANE_W]),
            .en    (cnt_en[g]),
            .clr   (clr_hit[g]),
            .hit   (lane_hit[g])
        );
    end

    logic [N_LANES-1:0] evt_c;

    always_comb begin
        st_d  = st_q;
        evt_c = '0;
        if (init_we)  st_d.init  = init_wdata;
        if (match_we) st_d.match = match_wdata;
        if (mode_we) begin
            st_d.mode = cnt_mode_e'(mode_wdata);
            st_d.cnt  = init_q;
        end else begin
            unique case (mode_q)
                MODE_BENCH: st_d.cnt = wide_nxt;
                MODE_EVT32: begin
                    st_d.cnt[EVT_W-1:0] = e32_nxt;
                    evt_c[0]            = e32_hit;
                end
                MODE_EVT16: begin
                    st_d.cnt[EVT_W-1:0] = lane_nxt;
                    evt_c               = lane_hit;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{mode: MODE_BENCH, cnt: '0, init: '0, match: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_val = st_q.cnt;
    assign dbg_evt = evt_c;

endmodule

// File: rtl/dbg_evt_counter_chk.sv
module dbg_evt_counter_chk
    import dbg_cnt_pkg::*;
#(
    parameter int WIDE_W = 40,
    parameter int EVT_W  = 32,
    parameter int LANE_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [EVT_W/LANE_W-1:0] cnt_en,
    input  logic [EVT_W/LANE_W-1:0] clr_hit,
    input  logic                    mode_we,
    input  logic [WIDE_W-1:0]       cnt_val,
    input  logic [EVT_W/LANE_W-1:0] dbg_evt,
    input  cnt_mode_e               mode_q,
    input  logic [WIDE_W-1:0]       init_q
);
    // R2
    bench_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_BENCH && !mode_we && cnt_en[0] && !clr_hit[0])
        |=> cnt_val == $past(cnt_val) + WIDE_W'(1));

    // R2
    bench_no_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_BENCH) |-> dbg_evt == '0);

    // R3
    evt32_upper_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_EVT32) |-> !dbg_evt[1]);

    // R4
    evt_needs_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_evt != '0) |-> ((dbg_evt & ~(cnt_en & ~clr_hit)) == '0));

    // R5
    evt16_top_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_EVT16 && !mode_we)
        |=> cnt_val[WIDE_W-1:EVT_W] == $past(cnt_val[WIDE_W-1:EVT_W]));

    // R6
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != MODE_HOLD && !mode_we && clr_hit[0])
        |=> cnt_val[LANE_W-1:0] == '0);

    // R7
    mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_we |=> cnt_val == $past(init_q));

    // R7
    mode_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_we |-> dbg_evt == '0);

    // R9
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_HOLD && !mode_we) |=> $stable(cnt_val));

endmodule

bind dbg_evt_counter dbg_evt_counter_chk #(
    .WIDE_W (WIDE_W),
    .EVT_W  (EVT_W),
    .LANE_W (LANE_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt_en  (cnt_en),
    .clr_hit (clr_hit),
    .mode_we (mode_we),
    .cnt_val (cnt_val),
    .dbg_evt (dbg_evt),
    .mode_q  (mode_q),
    .init_q  (init_q)
);

// File: tb/dbg_evt_counter_tb.sv
module dbg_evt_counter_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  cnt_en;
    logic [1:0]  clr_hit;
    logic        mode_we;
    logic [1:0]  mode_wdata;
    logic        init_we;
    logic [39:0] init_wdata;
    logic [31:0] match_wdata;
    logic        match_we;
    logic [39:0] cnt_val;
    logic [1:0]  dbg_evt;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_evt_counter u_dut (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .clr_hit(clr_hit),
        .mode_we(mode_we), .mode_wdata(mode_wdata), .init_we(init_we),
        .init_wdata(init_wdata), .match_wdata(match_wdata), .match_we(match_we),
        .cnt_val(cnt_val), .dbg_evt(dbg_evt)
    );

    task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge.
    task automatic tick(input logic [1:0] en, input logic [1:0] clr, output logic [1:0] evt);
        cnt_en = en; clr_hit = clr;
        #1 evt = dbg_evt;
        @(negedge clk);
        cnt_en = '0; clr_hit = '0;
    endtask

    task automatic set_init(input logic [39:0] v);
        init_we = 1'b1; init_wdata = v;
        @(negedge clk);
        init_we = 1'b0;
    endtask

    task automatic set_match(input logic [31:0] v);
        match_we = 1'b1; match_wdata = v;
        @(negedge clk);
        match_we = 1'b0;
    endtask

    task automatic set_mode(input logic [1:0] m, input logic [1:0] en, output logic [1:0] evt);
        mode_we = 1'b1; mode_wdata = m; cnt_en = en;
        #1 evt = dbg_evt;
        @(negedge clk);
        mode_we = 1'b0; cnt_en = '0;
    endtask

    task automatic t_reset();
        check("R1 cnt", cnt_val, 40'h0);
        check("R1 evt", {38'h0, dbg_evt}, 40'h0);
    endtask

    task automatic t_bench();
        logic [1:0] e;
        set_init(40'h0);
        set_mode(2'd0, 2'b00, e);
        for (int i = 0; i < 5; i++) begin
            tick(2'b01, 2'b00, e);
            check("R2 evt", {38'h0, e}, 40'h0);
        end
        tick(2'b00, 2'b00, e);
        check("R2 count5", cnt_val, 40'd5);
        set_init(40'hFF_FFFF_FFFF);
        set_mode(2'd0, 2'b00, e);
        tick(2'b01, 2'b00, e);
        check("R2 wrap40", cnt_val, 40'h0);
    endtask

    task automatic t_pre_inc();
        logic [1:0] e;
        set_init(40'h0);
        set_match(32'h0);
        set_mode(2'd1, 2'b00, e);
        tick(2'b01, 2'b00, e);
        check("R4 zero match evt", {38'h0, e}, 40'h1);
        check("R4 holds 1", cnt_val, 40'd1);
        tick(2'b01, 2'b00, e);
        check("R4 single pulse", {38'h0, e}, 40'h0);
        set_match(32'd5);
        check("R8 match write keeps cnt", cnt_val, 40'd2);
        tick(2'b01, 2'b00, e); tick(2'b01, 2'b00, e); tick(2'b01, 2'b00, e);
        check("R4 before match", {38'h0, e}, 40'h0);
        tick(2'b01, 2'b00, e);
        check("R4 match 5 evt", {38'h0, e}, 40'h1);
        check("R4 after match", cnt_val, 40'd6);
        set_init(40'h12_3456_7890);
        check("R8 init write keeps cnt", cnt_val, 40'd6);
    endtask

    task automatic t_wrap32();
        logic [1:0] e;
        set_init(40'hAB_FFFF_FFFF);
        set_match(32'h10);
        set_mode(2'd1, 2'b00, e);
        tick(2'b01, 2'b00, e);
        check("R3 wrap32", cnt_val, 40'hAB_0000_0000);
        check("R3 no evt on wrap", {38'h0, e}, 40'h0);
        tick(2'b10, 2'b10, e);
        check("R3 lane1 inputs ignored cnt", cnt_val, 40'hAB_0000_0000);
        check("R3 lane1 inputs ignored evt", {38'h0, e}, 40'h0);
    endtask

    task automatic t_split();
        logic [1:0] e;
        set_init(40'h5A_0003_FFFF);
        set_match({16'h0003, 16'hFFFF});
        set_mode(2'd2, 2'b00, e);
        tick(2'b11, 2'b00, e);
        check("R5 both lanes evt", {38'h0, e}, 40'h3);
        check("R5 no carry", cnt_val, 40'h5A_0004_0000);
        tick(2'b10, 2'b00, e);
        check("R5 lane1 only", cnt_val, 40'h5A_0005_0000);
        check("R5 lane1 no evt", {38'h0, e}, 40'h0);
        tick(2'b11, 2'b01, e);
        check("R6 lane0 clear lane1 count", cnt_val, 40'h5A_0006_0000);
    endtask

    task automatic t_watchdog();
        logic [1:0] e;
        set_init(40'h0);
        set_match(32'd3);
        set_mode(2'd1, 2'b00, e);
        tick(2'b01, 2'b00, e); tick(2'b01, 2'b00, e);
        tick(2'b01, 2'b01, e);
        check("R6 clear wins", cnt_val, 40'h0);
        check("R6 no evt on clear", {38'h0, e}, 40'h0);
        tick(2'b01, 2'b00, e); tick(2'b01, 2'b00, e); tick(2'b01, 2'b00, e);
        check("R6 not yet expired", {38'h0, e}, 40'h0);
        tick(2'b01, 2'b00, e);
        check("R6 watchdog evt", {38'h0, e}, 40'h1);
        set_mode(2'd0, 2'b00, e);
        tick(2'b00, 2'b01, e);
        check("R6 bench clear", cnt_val, 40'h0);
    endtask

    task automatic t_mode_write();
        logic [1:0] e;
        set_init(40'd7);
        set_match(32'd7);
        set_mode(2'd1, 2'b00, e);
        set_init(40'd9);
        set_mode(2'd1, 2'b01, e);
        check("R7 no evt in write", {38'h0, e}, 40'h0);
        check("R7 load init", cnt_val, 40'd9);
    endtask

    task automatic t_frozen();
        logic [1:0] e;
        set_init(40'h42);
        set_match(32'h42);
        set_mode(2'd3, 2'b00, e);
        tick(2'b11, 2'b00, e);
        check("R9 frozen evt", {38'h0, e}, 40'h0);
        check("R9 frozen cnt", cnt_val, 40'h42);
        tick(2'b00, 2'b11, e);
        check("R9 frozen clear", cnt_val, 40'h42);
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cnt_en = '0; clr_hit = '0; mode_we = 1'b0; mode_wdata = '0;
        init_we = 1'b0; init_wdata = '0; match_we = 1'b0; match_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bench();
        t_pre_inc();
        t_wrap32();
        t_split();
        t_watchdog();
        t_mode_write();
        t_frozen();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule